// File: doc/BRIEF.md
# DMA Channel Priority Arbiter

This block is the shared front end of a six-channel DMA engine. It decides, once per clock, which of the channels asking for the shared bus receives the next transfer slot. The grant is registered and one-hot. One of four ranking schemes applies, chosen at run time through a two-bit field in the global control word: three fixed orders and a rotating order that moves past the channel served last.

The same block holds the global controls. These are a master enable that software reads back to confirm that the engine is on or off, a sticky halt flag, and a sticky address-error flag. Any channel can raise either flag through its event line. Either flag stops all grants until software clears it. The block also presents a read-only pending word that gathers the six channel interrupt lines. Channel 0 sits at the top of that word, so the bit order is reversed relative to channel numbers.

The control word sits at offset 0xFC of the global register space and the pending word at 0xF8. Each channel's own register window is at a stride of 0x20 from the base, but those windows belong to the channel datapaths and are outside this block.

Top module: `dma_prio_arb`

## Requirements
- R1: A write to offset 0xFC loads bit 0 into the master enable; `gbl_en` and bit 0 of a read at 0xFC show the new value from the cycle after the write.
- R2: While the master enable is clear, `grant` stays zero whatever the requests are.
- R3: With the mode field (bits 9:8 of the control word) at 0, the lowest-numbered requesting channel wins.
- R4: With the mode field at 1, channels rank 0, 2, 3, 1, 4, 5, highest first.
- R5: With the mode field at 2, channels rank 2, 0, 1, 3, 4, 5, highest first.
- R6: With the mode field at 3, the winner is the first requesting channel above the last granted channel, wrapping from 5 to 0. After reset the search starts at channel 0.
- R7: A pulse on any `ch_halt` line sets the halt flag (bit 3 at 0xFC) from the next cycle, and the flag then blocks all grants. A control write with bit 3 at 0 clears the flag. A control write with bit 3 at 1 leaves it as it is.
- R8: The address-error flag (bit 2 at 0xFC) follows the same rules as the halt flag, driven by the `ch_aerr` lines.
- R9: When a flag-setting event and a control write that clears the same flag fall in one cycle, the flag stays set.
- R10: A read at 0xF8 returns `ch_irq[n]` in bit 15-n for every channel n, with all other bits at zero. A pending bit clears as soon as its interrupt line drops.
- R11: `grant` is one-hot or zero. It appears one cycle after the request is sampled, names only a channel that requested in that sampled cycle, and is zero when no channel requests.
- R12: After reset, `grant`, `gbl_en`, both flags, the mode field and the last-granted pointer are in their idle state. A read at 0xFC then returns zero.
- R13: A write to any offset other than 0xFC leaves the control word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_req | input | 6 | Per-channel bus request |
| ch_irq | input | 6 | Per-channel completion interrupt, level |
| ch_halt | input | 6 | Per-channel halt event pulse |
| ch_aerr | input | 6 | Per-channel address-error event pulse |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register offset for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| grant | output | 6 | One-hot bus grant |
| gbl_en | output | 1 | Master enable |

## Verification
Two functions can act on the same control flag in one cycle. A channel event can set a flag in the same cycle that a software write clears it. The bench provokes this by driving a `ch_halt` pulse at the same edge as a control write with bit 3 at zero. It then judges the result at the ports: the flag must still read back as set, and `grant` must stay zero. It also checks that the flag is not cleared by a write with bit 3 at one, and that grants resume in the very cycle after a plain clearing write.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

    // Fixed ranking tables are eight entries long; channel count must not exceed this.
    localparam int MAX_CH = 8;

    localparam int CTL_EN_BIT   = 0;
    localparam int CTL_AERR_BIT = 2;
    localparam int CTL_HALT_BIT = 3;
    localparam int CTL_MODE_LSB = 8;
    localparam int PEND_TOP_BIT = 15;

    typedef enum logic [1:0] {
        PRIO_LINEAR = 2'd0,
        PRIO_MIX_A  = 2'd1,
        PRIO_MIX_B  = 2'd2,
        PRIO_ROTATE = 2'd3
    } prio_mode_e;

    typedef struct packed {
        prio_mode_e mode;
        logic       halt;
        logic       aerr;
        logic       en;
    } gctl_t;

    // Entry k of the ranking for a fixed mode; entry 0 is the highest rank.
    // Packed with entry 0 in the least significant three bits.
    function automatic logic [2:0] rank_entry(prio_mode_e m, int k);
        logic [23:0] tbl;
        case (m)
            PRIO_MIX_A: tbl = {3'd5, 3'd7, 3'd6, 3'd4, 3'd1, 3'd3, 3'd2, 3'd0};
            PRIO_MIX_B: tbl = {3'd7, 3'd5, 3'd4, 3'd6, 3'd3, 3'd1, 3'd0, 3'd2};
            default:    tbl = {3'd7, 3'd6, 3'd5, 3'd4, 3'd3, 3'd2, 3'd1, 3'd0};
        endcase
        return tbl[3*k +: 3];
    endfunction

    // Build the readable control word from the held state.
    function automatic logic [31:0] pack_ctl(gctl_t c);
        logic [31:0] w;
        w = '0;
        w[CTL_EN_BIT]            = c.en;
        w[CTL_AERR_BIT]          = c.aerr;
        w[CTL_HALT_BIT]          = c.halt;
        w[CTL_MODE_LSB +: 2]     = c.mode;
        return w;
    endfunction

endpackage

// File: rtl/dma_arb_ctl.sv
module dma_arb_ctl
    import dma_arb_pkg::*;
#(
    parameter int NCH     = 6,
    parameter int AW      = 8,
    parameter int DW      = 32,
    parameter int CTL_OFS = 'hFC
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [NCH-1:0] halt_evt,
    input  logic [NCH-1:0] aerr_evt,
    output gctl_t         ctl_q,
    output gctl_t         ctl_nxt
);

    localparam logic [AW-1:0] CTL_ADDR = AW'(CTL_OFS);

    logic hit;
    logic unused_wdata;

    assign unused_wdata = ^wr_data;
    assign hit = wr_en && (wr_addr == CTL_ADDR);

    always_comb begin
        ctl_nxt = ctl_q;
        if (hit) begin
            ctl_nxt.en   = wr_data[CTL_EN_BIT];
            ctl_nxt.mode = prio_mode_e'(wr_data[CTL_MODE_LSB +: 2]);
            if (!wr_data[CTL_HALT_BIT]) ctl_nxt.halt = 1'b0;
            if (!wr_data[CTL_AERR_BIT]) ctl_nxt.aerr = 1'b0;
        end
        // hardware events win over a clearing write in the same cycle
        if (|halt_evt) ctl_nxt.halt = 1'b1;
        if (|aerr_evt) ctl_nxt.aerr = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '{mode: PRIO_LINEAR, halt: 1'b0, aerr: 1'b0, en: 1'b0};
        end else begin
            ctl_q <= ctl_nxt;
        end
    end

endmodule

// File: rtl/dma_arb_pend.sv
module dma_arb_pend
    import dma_arb_pkg::*;
#(
    parameter int NCH = 6,
    parameter int DW  = 32
) (
    input  logic [NCH-1:0] irq,
    output logic [DW-1:0]  pend_word
);

    always_comb begin
        pend_word = '0;
        for (int n = 0; n < NCH; n++) begin
            pend_word[PEND_TOP_BIT - n] = irq[n];
        end
    end

endmodule

// File: rtl/dma_arb_pick.sv
module dma_arb_pick
    import dma_arb_pkg::*;
#(
    parameter int NCH = 6,
    localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic [NCH-1:0]   req,
    input  prio_mode_e       mode,
    input  logic [IDX_W-1:0] last,
    output logic             pick_any,
    output logic [IDX_W-1:0] pick_idx,
    output logic [NCH-1:0]   pick_vec
);

    logic             fx_hit, rr_hit;
    logic [IDX_W-1:0] fx_idx, rr_idx;

    // fixed ranking: walk the table, skipping entries for absent channels
    always_comb begin
        fx_hit = 1'b0;
        fx_idx = '0;
        for (int k = 0; k < MAX_CH; k++) begin
            logic [2:0] e;
            e = rank_entry(mode, k);
            if (!fx_hit && (int'(e) < NCH)) begin
                if (req[e]) begin
                    fx_hit = 1'b1;
                    fx_idx = IDX_W'(e);
                end
            end
        end
    end

    // rotating ranking: start one above the last winner
    always_comb begin
        rr_hit = 1'b0;
        rr_idx = '0;
        for (int k = 1; k <= NCH; k++) begin
            int c;
            c = (int'(last) + k) % NCH;
            if (!rr_hit && req[c]) begin
                rr_hit = 1'b1;
                rr_idx = IDX_W'(c);
            end
        end
    end

    always_comb begin
        if (mode == PRIO_ROTATE) begin
            pick_any = rr_hit;
            pick_idx = rr_idx;
        end else begin
            pick_any = fx_hit;
            pick_idx = fx_idx;
        end
        pick_vec = pick_any ? (NCH'(1) << pick_idx) : '0;
    end

endmodule

// File: rtl/dma_arb_grant.sv
module dma_arb_grant #(
    parameter int NCH = 6,
    localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             allow,
    input  logic             pick_any,
    input  logic [IDX_W-1:0] pick_idx,
    input  logic [NCH-1:0]   pick_vec,
    output logic [NCH-1:0]   grant_q,
    output logic [IDX_W-1:0] last_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            grant_q <= '0;
            last_q  <= IDX_W'(NCH - 1);
        end else if (allow && pick_any) begin
            grant_q <= pick_vec;
            last_q  <= pick_idx;
        end else begin
            grant_q <= '0;
        end
    end

endmodule

// File: rtl/dma_prio_arb.sv
module dma_prio_arb
    import dma_arb_pkg::*;
#(
    parameter int NCH      = 6,
    parameter int AW       = 8,
    parameter int DW       = 32,
    parameter int CTL_OFS  = 'hFC,
    parameter int PEND_OFS = 'hF8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] ch_req,
    input  logic [NCH-1:0] ch_irq,
    input  logic [NCH-1:0] ch_halt,
    input  logic [NCH-1:0] ch_aerr,
    input  logic           reg_we,
    input  logic [AW-1:0]  reg_addr,
    input  logic [DW-1:0]  reg_wdata,
    output logic [DW-1:0]  reg_rdata,
    output logic [NCH-1:0] grant,
    output logic           gbl_en
);

    localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1;
    localparam logic [AW-1:0] CTL_ADDR  = AW'(CTL_OFS);
    localparam logic [AW-1:0] PEND_ADDR = AW'(PEND_OFS);

    gctl_t            ctl_q, ctl_nxt;
    logic [DW-1:0]    pend_word;
    logic             pick_any;
    logic [IDX_W-1:0] pick_idx, last_q;
    logic [NCH-1:0]   pick_vec;
    logic             allow;
    logic             halt_flag, aerr_flag;
    logic [31:0]      ctl_word;

    dma_arb_ctl #(.NCH(NCH), .AW(AW), .DW(DW), .CTL_OFS(CTL_OFS)) u_ctl (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (reg_we),
        .wr_addr  (reg_addr),
        .wr_data  (reg_wdata),
        .halt_evt (ch_halt),
        .aerr_evt (ch_aerr),
        .ctl_q    (ctl_q),
        .ctl_nxt  (ctl_nxt)
    );

    dma_arb_pend #(.NCH(NCH), .DW(DW)) u_pend (
        .irq       (ch_irq),
        .pend_word (pend_word)
    );

    dma_arb_pick #(.NCH(NCH)) u_pick (
        .req      (ch_req),
        .mode     (ctl_q.mode),
        .last     (last_q),
        .pick_any (pick_any),
        .pick_idx (pick_idx),
        .pick_vec (pick_vec)
    );

    // gate on the next control state so a fresh flag blocks the very next grant
    assign allow = ctl_nxt.en && !ctl_nxt.halt && !ctl_nxt.aerr;

    dma_arb_grant #(.NCH(NCH)) u_grant (
        .clk      (clk),
        .rst      (rst),
        .allow    (allow),
        .pick_any (pick_any),
        .pick_idx (pick_idx),
        .pick_vec (pick_vec),
        .grant_q  (grant),
        .last_q   (last_q)
    );

    assign halt_flag = ctl_q.halt;
    assign aerr_flag = ctl_q.aerr;
    assign gbl_en    = ctl_q.en;
    assign ctl_word  = pack_ctl(ctl_q);

    always_comb begin
        if (reg_addr == CTL_ADDR)       reg_rdata = DW'(ctl_word);
        else if (reg_addr == PEND_ADDR) reg_rdata = pend_word;
        else                            reg_rdata = '0;
    end

endmodule

// File: rtl/dma_prio_arb_chk.sv
module dma_prio_arb_chk #(
    parameter int NCH     = 6,
    parameter int AW      = 8,
    parameter int DW      = 32,
    parameter int CTL_OFS = 'hFC
) (
    input logic           clk,
    input logic           rst,
    input logic [NCH-1:0] ch_req,
    input logic [NCH-1:0] ch_halt,
    input logic [NCH-1:0] ch_aerr,
    input logic           reg_we,
    input logic [AW-1:0]  reg_addr,
    input logic [DW-1:0]  reg_wdata,
    input logic [NCH-1:0] grant,
    input logic           gbl_en,
    input logic           halt_flag,
    input logic           aerr_flag
);

    localparam logic [AW-1:0] CTL_ADDR = AW'(CTL_OFS);

    // R11
    grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    // R11
    grant_from_req_chk: assert property (@(posedge clk) disable iff (rst)
        (grant & ~$past(ch_req)) == '0);

    // R2
    grant_needs_go_chk: assert property (@(posedge clk) disable iff (rst)
        (|grant) |-> (gbl_en && !halt_flag && !aerr_flag));

    // R1
    en_write_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == CTL_ADDR) |=> (gbl_en == $past(reg_wdata[0])));

    // R7
    halt_set_chk: assert property (@(posedge clk) disable iff (rst)
        (|ch_halt) |=> halt_flag);

    // R8
    aerr_set_chk: assert property (@(posedge clk) disable iff (rst)
        (|ch_aerr) |=> aerr_flag);

    // R7
    halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (halt_flag && !(reg_we && reg_addr == CTL_ADDR && !reg_wdata[3])) |=> halt_flag);

endmodule

bind dma_prio_arb dma_prio_arb_chk #(
    .NCH(NCH), .AW(AW), .DW(DW), .CTL_OFS(CTL_OFS)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ch_req    (ch_req),
    .ch_halt   (ch_halt),
    .ch_aerr   (ch_aerr),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .grant     (grant),
    .gbl_en    (gbl_en),
    .halt_flag (halt_flag),
    .aerr_flag (aerr_flag)
);

// File: tb/dma_prio_arb_bench.sv
module dma_prio_arb_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  ch_req = '0, ch_irq = '0, ch_halt = '0, ch_aerr = '0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = 8'hFC;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [5:0]  grant;
    logic        gbl_en;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    dma_prio_arb u_dma_prio_arb (
        .clk(clk), .rst(rst), .ch_req(ch_req), .ch_irq(ch_irq),
        .ch_halt(ch_halt), .ch_aerr(ch_aerr), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .grant(grant), .gbl_en(gbl_en)
    );

    typedef struct packed {
        logic [1:0] m;
        logic [5:0] rq;
        logic [5:0] ex;
    } vec_t;

    localparam vec_t TBL [14] = '{
        '{2'd0, 6'h3F, 6'h01}, '{2'd0, 6'h3E, 6'h02}, '{2'd0, 6'h30, 6'h10},
        '{2'd0, 6'h20, 6'h20},
        '{2'd1, 6'h3E, 6'h04}, '{2'd1, 6'h0A, 6'h08}, '{2'd1, 6'h32, 6'h02},
        '{2'd1, 6'h30, 6'h10}, '{2'd1, 6'h20, 6'h20},
        '{2'd2, 6'h3F, 6'h04}, '{2'd2, 6'h0B, 6'h01}, '{2'd2, 6'h0A, 6'h02},
        '{2'd2, 6'h30, 6'h10}, '{2'd2, 6'h28, 6'h08}
    };

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    task automatic wr_ctl(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_addr = 8'hFC;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
        reg_addr = 8'hFC;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; ch_req = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin : watchdog
        #(20 * 20000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        logic [31:0] r;

        // R12 reset state
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R12 grant after reset", 32'(grant), 0);
        check("R12 gbl_en after reset", 32'(gbl_en), 0);
        rd(8'hFC, r); check("R12 ctl after reset", r, 0);

        // R2 requests while disabled
        ch_req = 6'h3F;
        repeat (2) @(negedge clk);
        check("R2 no grant while disabled", 32'(grant), 0);
        ch_req = '0;

        // R1 enable readback
        wr_ctl(8'hFC, 32'h1);
        check("R1 gbl_en set", 32'(gbl_en), 1);
        rd(8'hFC, r); check("R1 ctl readback set", r, 32'h1);
        wr_ctl(8'hFC, 32'h0);
        check("R1 gbl_en clear", 32'(gbl_en), 0);

        // R13 write elsewhere ignored
        wr_ctl(8'hFC, 32'h1);
        wr_ctl(8'hF8, 32'h30C);
        wr_ctl(8'h20, 32'h0);
        rd(8'hFC, r); check("R13 ctl unchanged", r, 32'h1);

        // R3 R4 R5 fixed orders from table
        for (int i = 0; i < 14; i++) begin
            string tag;
            case (TBL[i].m)
                2'd0:    tag = "R3 linear order";
                2'd1:    tag = "R4 mixed order A";
                default: tag = "R5 mixed order B";
            endcase
            wr_ctl(8'hFC, {22'd0, TBL[i].m, 8'h01});
            ch_req = TBL[i].rq;
            @(negedge clk);
            check(tag, 32'(grant), 32'(TBL[i].ex));
            ch_req = '0;
        end

        // R11 no requests gives no grant
        @(negedge clk);
        check("R11 idle grant", 32'(grant), 0);

        // R7 halt event blocks grants, sticky, write-one keeps, write-zero clears
        wr_ctl(8'hFC, 32'h1);
        ch_req = 6'h3F;
        @(negedge clk);
        check("R11 grant running", 32'(grant), 32'h01);
        ch_halt = 6'b000100;
        @(negedge clk);
        ch_halt = '0;
        check("R7 halt blocks grant", 32'(grant), 0);
        rd(8'hFC, r); check("R7 halt flag set", r, 32'h9);
        @(negedge clk);
        check("R7 halt sticky", 32'(grant), 0);
        wr_ctl(8'hFC, 32'h9);
        rd(8'hFC, r); check("R7 write one keeps halt", r, 32'h9);
        wr_ctl(8'hFC, 32'h1);
        rd(8'hFC, r); check("R7 halt cleared", r, 32'h1);
        check("R7 grant resumes", 32'(grant), 32'h01);

        // R8 address error
        ch_aerr = 6'b100000;
        @(negedge clk);
        ch_aerr = '0;
        check("R8 aerr blocks grant", 32'(grant), 0);
        rd(8'hFC, r); check("R8 aerr flag set", r, 32'h5);
        wr_ctl(8'hFC, 32'h1);
        rd(8'hFC, r); check("R8 aerr cleared", r, 32'h1);

        // R9 event and clearing write in the same cycle
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 8'hFC; reg_wdata = 32'h1; ch_halt = 6'b000001;
        @(negedge clk);
        reg_we = 1'b0; ch_halt = '0;
        rd(8'hFC, r); check("R9 halt survives clear", r, 32'h9);
        check("R9 grant stays off", 32'(grant), 0);
        wr_ctl(8'hFC, 32'h1);
        ch_req = '0;

        // R10 pending word
        ch_irq = 6'b000001; #1;
        rd(8'hF8, r); check("R10 ch0 pending", r, 32'h8000);
        ch_irq = 6'b100000; #1;
        rd(8'hF8, r); check("R10 ch5 pending", r, 32'h0400);
        ch_irq = 6'b101101; #1;
        rd(8'hF8, r); check("R10 mixed pending", r, 32'hB400);
        ch_irq = '0; #1;
        rd(8'hF8, r); check("R10 pending cleared", r, 32'h0);

        // R6 rotating order from reset
        do_reset();
        wr_ctl(8'hFC, 32'h301);
        ch_req = 6'h3F;
        for (int k = 0; k < 7; k++) begin
            @(negedge clk);
            check("R6 rotate full", 32'(grant), 32'(6'h01 << (k % 6)));
        end
        ch_req = 6'h24;
        @(negedge clk); check("R6 rotate sparse a", 32'(grant), 32'h04);
        @(negedge clk); check("R6 rotate sparse b", 32'(grant), 32'h20);
        @(negedge clk); check("R6 rotate sparse wrap", 32'(grant), 32'h04);
        ch_req = '0;
        @(negedge clk); check("R11 no request no grant", 32'(grant), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule